// File: doc/BRIEF.md
# Outbound Address Translator with Indirect Region Window

This block maps addresses issued on the CPU side of a PCIe root port onto PCIe bus addresses and tells the downstream logic which transaction kind to issue: memory, I/O, type-0 configuration or type-1 configuration. It holds a small, parameterised set of translation regions. Each region has an enable, a transaction kind, a 64-bit base, a 32-bit limit and a 64-bit target.

Software does not address the regions directly. It first writes a region number and a direction bit into a window-select register. The seven region registers at the following offsets then access the selected region. This lets a driver reprogram one region, for example to retarget a configuration access to a new bus, device and function, between two accesses.

On the datapath side, a request address is compared in the same cycle against every enabled region. On a hit, the block returns the translated address, the region's kind and the number of the winning region. On a miss, it returns the address unchanged with the hit flag low.

Top module: `atu_outbound`

## Requirements
- R1: The window-select register sits at offset 0x900. Bit 31 is the direction bit (1 = inbound, 0 = outbound) and bits [IDX_FIELD_W-1:0] hold the region number. Reading it returns exactly those bits as last written, with every other bit reading as zero.
- R2: The region registers are at these offsets:
  - 0x904: kind, in bits [2:0].
  - 0x908: enable, in bit 31.
  - 0x90C: base low word.
  - 0x910: base high word.
  - 0x914: limit.
  - 0x918: target low word.
  - 0x91C: target high word.

  Reads and writes at these offsets reach the currently selected region. Unused bits of kind and enable read as zero.
- R3: The selection is unusable while the direction bit is 1 or the region number is NUM_REGIONS or above. In that state, reads at region offsets return zero and writes at them change no region. Offsets other than the eight listed, including unaligned ones, read as zero and are ignored on write.
- R4: After reset every region is disabled and all its fields are zero. The window-select register is zero, and every request misses.
- R5: A request hits a region when all four of the following hold:
  - the region is enabled;
  - address bits [63:32] equal the base high word;
  - address bits [31:0] are at or above the base low word;
  - address bits [31:0] are at or below the limit.

  Both the base and the limit are inside the region.
- R6: On a hit, the output address is the 64-bit target plus (request address minus the 64-bit base), and the kind output is the region's kind: 0 memory, 2 I/O, 4 type-0 configuration, 5 type-1 configuration. For a configuration target, the bus, device and function numbers written in target-low bits [31:24], [23:19] and [18:16] appear at those output bits when the offset is below 64 KiB.
- R7: A disabled region never hits, whatever its other fields hold.
- R8: When several regions hit, the lowest-numbered one supplies the outputs, and its number appears on hit_region_o.
- R9: On a miss, hit_o is 0, the output address equals the request address and the kind output is 0.
- R10: Translation is combinational from the request address. A register write becomes visible at both the read port and the translation outputs from the clock edge that accepts it, and outputs stay unchanged while neither the request nor the registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset, used for both reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| req_addr_i | input | 64 | CPU-side request address |
| xlat_addr_o | output | 64 | Translated address, or the request address on a miss |
| xlat_type_o | output | 3 | Transaction kind of the winning region, 0 on a miss |
| hit_o | output | 1 | Some enabled region covers the request |
| hit_region_o | output | $clog2(NUM_REGIONS) | Number of the winning region |

## Verification
Read data and all translation outputs are combinational, so they are due in the same cycle as the offset or address that produces them. The bench drives inputs on the falling edge and samples one time unit later, inside the same low phase. A register write is accepted at the next rising edge. The bench therefore holds the strobe for exactly one rising edge and releases it on the following falling edge, and only then reads back or translates against the updated reference model. The bench checks both edges of every region directly (base, base minus one, limit, limit plus one) and then runs a random mix of register writes through valid and blocked selections interleaved with translations.

// File: rtl/atu_pkg.sv
package atu_pkg;

  localparam int unsigned OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_SELECT  = 12'h900;
  localparam logic [OFS_W-1:0] OFS_KIND    = 12'h904;
  localparam logic [OFS_W-1:0] OFS_ENABLE  = 12'h908;
  localparam logic [OFS_W-1:0] OFS_BASE_LO = 12'h90C;
  localparam logic [OFS_W-1:0] OFS_BASE_HI = 12'h910;
  localparam logic [OFS_W-1:0] OFS_LIMIT   = 12'h914;
  localparam logic [OFS_W-1:0] OFS_TGT_LO  = 12'h918;
  localparam logic [OFS_W-1:0] OFS_TGT_HI  = 12'h91C;

  localparam logic [2:0] KIND_MEM  = 3'd0;
  localparam logic [2:0] KIND_IO   = 3'd2;
  localparam logic [2:0] KIND_CFG0 = 3'd4;
  localparam logic [2:0] KIND_CFG1 = 3'd5;

  typedef enum logic [2:0] {
    FLD_KIND,
    FLD_ENABLE,
    FLD_BASE_LO,
    FLD_BASE_HI,
    FLD_LIMIT,
    FLD_TGT_LO,
    FLD_TGT_HI,
    FLD_NONE
  } field_e;

  typedef struct packed {
    logic        en;
    logic [2:0]  kind;
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] limit;
    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
  } region_t;

endpackage

// File: rtl/atu_reg_decode.sv
module atu_reg_decode
  import atu_pkg::*;
(
  input  logic [OFS_W-1:0] ofs_i,
  output logic             is_select_o,
  output field_e           field_o
);

  always_comb begin
    is_select_o = (ofs_i == OFS_SELECT);
    unique case (ofs_i)
      OFS_KIND:    field_o = FLD_KIND;
      OFS_ENABLE:  field_o = FLD_ENABLE;
      OFS_BASE_LO: field_o = FLD_BASE_LO;
      OFS_BASE_HI: field_o = FLD_BASE_HI;
      OFS_LIMIT:   field_o = FLD_LIMIT;
      OFS_TGT_LO:  field_o = FLD_TGT_LO;
      OFS_TGT_HI:  field_o = FLD_TGT_HI;
      default:     field_o = FLD_NONE;
    endcase
  end

endmodule

// File: rtl/atu_region_regs.sv
module atu_region_regs
  import atu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  field_e                        wr_field_i,
  input  logic [31:0]                   wr_data_i,
  output region_t [NUM_REGIONS-1:0]     regions_o
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    region_t r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
      end else if (wr_en_i && wr_idx_i == MY_IDX) begin
        unique case (wr_field_i)
          FLD_KIND:    r_q.kind    <= wr_data_i[2:0];
          FLD_ENABLE:  r_q.en      <= wr_data_i[31];
          FLD_BASE_LO: r_q.base_lo <= wr_data_i;
          FLD_BASE_HI: r_q.base_hi <= wr_data_i;
          FLD_LIMIT:   r_q.limit   <= wr_data_i;
          FLD_TGT_LO:  r_q.tgt_lo  <= wr_data_i;
          FLD_TGT_HI:  r_q.tgt_hi  <= wr_data_i;
          default:     r_q         <= r_q;
        endcase
      end
    end

    assign regions_o[g] = r_q;
  end

endmodule

// File: rtl/atu_region_match.sv
module atu_region_match
  import atu_pkg::*;
(
  input  region_t     region_i,
  input  logic [63:0] addr_i,
  output logic        hit_o,
  output logic [63:0] xaddr_o
);

  logic        upper_eq;
  logic        above_base;
  logic        below_limit;
  logic [63:0] base64;
  logic [63:0] tgt64;

  assign base64      = {region_i.base_hi, region_i.base_lo};
  assign tgt64       = {region_i.tgt_hi, region_i.tgt_lo};
  assign upper_eq    = (addr_i[63:32] == region_i.base_hi);
  assign above_base  = (addr_i[31:0] >= region_i.base_lo);
  // limit is a 32-bit bound within the base's 4 GiB page
  assign below_limit = (addr_i[31:0] <= region_i.limit);

  assign hit_o   = region_i.en && upper_eq && above_base && below_limit;
  assign xaddr_o = tgt64 + (addr_i - base64);

endmodule

// File: rtl/atu_prio_pick.sv
module atu_prio_pick #(
  parameter int unsigned NUM_REGIONS = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0] hits_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    // descending scan: the last assignment, the lowest index, wins
    for (int i = int'(NUM_REGIONS) - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/atu_outbound.sv
module atu_outbound
  import atu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned IDX_FIELD_W = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [OFS_W-1:0]  reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [63:0]       req_addr_i,
  output logic [63:0]       xlat_addr_o,
  output logic [2:0]        xlat_type_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_region_o
);

  localparam logic [IDX_FIELD_W:0] REGION_CNT = (IDX_FIELD_W + 1)'(NUM_REGIONS);

  logic                    sel_dir_q;
  logic [IDX_FIELD_W-1:0]  sel_idx_q;
  logic                    sel_ok;
  logic [IDX_W-1:0]        sel_idx;
  logic                    is_select;
  field_e                  field;
  region_t [NUM_REGIONS-1:0] regions;
  region_t                 cur;
  logic [NUM_REGIONS-1:0]  hits;
  logic [63:0]             cand_addr [NUM_REGIONS];
  logic                    any_hit;
  logic [IDX_W-1:0]        win_idx;

  atu_reg_decode u_dec (
    .ofs_i       (reg_addr_i),
    .is_select_o (is_select),
    .field_o     (field)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_dir_q <= 1'b0;
      sel_idx_q <= '0;
    end else if (reg_wr_i && is_select) begin
      sel_dir_q <= reg_wdata_i[31];
      sel_idx_q <= reg_wdata_i[IDX_FIELD_W-1:0];
    end
  end

  assign sel_ok  = !sel_dir_q && ({1'b0, sel_idx_q} < REGION_CNT);
  assign sel_idx = sel_idx_q[IDX_W-1:0];

  atu_region_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_wr_i && sel_ok && field != FLD_NONE),
    .wr_idx_i   (sel_idx),
    .wr_field_i (field),
    .wr_data_i  (reg_wdata_i),
    .regions_o  (regions)
  );

  assign cur = regions[sel_idx];

  always_comb begin
    reg_rdata_o = '0;
    if (is_select) begin
      reg_rdata_o[31]              = sel_dir_q;
      reg_rdata_o[IDX_FIELD_W-1:0] = sel_idx_q;
    end else if (sel_ok) begin
      unique case (field)
        FLD_KIND:    reg_rdata_o[2:0] = cur.kind;
        FLD_ENABLE:  reg_rdata_o[31]  = cur.en;
        FLD_BASE_LO: reg_rdata_o      = cur.base_lo;
        FLD_BASE_HI: reg_rdata_o      = cur.base_hi;
        FLD_LIMIT:   reg_rdata_o      = cur.limit;
        FLD_TGT_LO:  reg_rdata_o      = cur.tgt_lo;
        FLD_TGT_HI:  reg_rdata_o      = cur.tgt_hi;
        default:     reg_rdata_o      = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    atu_region_match u_match (
      .region_i (regions[g]),
      .addr_i   (req_addr_i),
      .hit_o    (hits[g]),
      .xaddr_o  (cand_addr[g])
    );
  end

  atu_prio_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .hits_i (hits),
    .any_o  (any_hit),
    .idx_o  (win_idx)
  );

  assign hit_o        = any_hit;
  assign hit_region_o = win_idx;
  assign xlat_addr_o  = any_hit ? cand_addr[win_idx] : req_addr_i;
  assign xlat_type_o  = any_hit ? regions[win_idx].kind : KIND_MEM;

endmodule

// File: rtl/atu_outbound_chk.sv
module atu_outbound_chk
  import atu_pkg::*;
#(
  parameter int unsigned IDX_FIELD_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [OFS_W-1:0] reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [31:0]      reg_rdata_o,
  input logic [63:0]      req_addr_i,
  input logic [63:0]      xlat_addr_o,
  input logic [2:0]       xlat_type_o,
  input logic             hit_o,
  input logic             sel_ok
);

  localparam logic [31:0] SEL_MASK = 32'h8000_0000 | ((32'd1 << IDX_FIELD_W) - 32'd1);

  logic in_window;
  assign in_window = (reg_addr_i >= OFS_KIND) && (reg_addr_i <= OFS_TGT_HI) &&
                     (reg_addr_i[1:0] == 2'b00);

  // R3
  blocked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_window && !sel_ok) |-> (reg_rdata_o == 32'h0));

  // R3
  blocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && in_window && !sel_ok) |=>
      (!$stable(req_addr_i) || ($stable(xlat_addr_o) && $stable(hit_o))));

  // R9
  miss_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (xlat_addr_o == req_addr_i && xlat_type_o == KIND_MEM));

  // R1
  select_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_SELECT && $past(reg_wr_i && reg_addr_i == OFS_SELECT)) |->
      (reg_rdata_o == ($past(reg_wdata_i) & SEL_MASK)));

  // R10
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(reg_wr_i) && $stable(req_addr_i)) |->
      ($stable(xlat_addr_o) && $stable(hit_o) && $stable(xlat_type_o)));

endmodule

bind atu_outbound atu_outbound_chk #(.IDX_FIELD_W(IDX_FIELD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .req_addr_i  (req_addr_i),
  .xlat_addr_o (xlat_addr_o),
  .xlat_type_o (xlat_type_o),
  .hit_o       (hit_o),
  .sel_ok      (sel_ok)
);

// File: tb/atu_outbound_test.sv
module atu_outbound_test;

  localparam int NR  = 4;
  localparam int IFW = 4;
  localparam int IW  = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [63:0]   req_addr = '0;
  logic [63:0]   xlat_addr;
  logic [2:0]    xlat_type;
  logic          hit;
  logic [IW-1:0] hit_region;

  always #5 clk = ~clk;

  atu_outbound #(.NUM_REGIONS(NR), .IDX_FIELD_W(IFW)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .req_addr_i   (req_addr),
    .xlat_addr_o  (xlat_addr),
    .xlat_type_o  (xlat_type),
    .hit_o        (hit),
    .hit_region_o (hit_region)
  );

  // reference model of the register state
  logic           m_en   [NR];
  logic [2:0]     m_kind [NR];
  logic [31:0]    m_blo  [NR];
  logic [31:0]    m_bhi  [NR];
  logic [31:0]    m_lim  [NR];
  logic [31:0]    m_tlo  [NR];
  logic [31:0]    m_thi  [NR];
  logic           m_dir;
  logic [IFW-1:0] m_idx;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic sel_valid();
    return !m_dir && (int'(m_idx) < NR);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] ofs);
    int i;
    i = int'(m_idx);
    if (ofs == 12'h900) return {m_dir, {(31 - IFW){1'b0}}, m_idx};
    if (!sel_valid()) return 32'h0;
    case (ofs)
      12'h904: return {29'h0, m_kind[i]};
      12'h908: return {m_en[i], 31'h0};
      12'h90C: return m_blo[i];
      12'h910: return m_bhi[i];
      12'h914: return m_lim[i];
      12'h918: return m_tlo[i];
      12'h91C: return m_thi[i];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] ofs, input logic [31:0] d);
    int i;
    i = int'(m_idx);
    if (ofs == 12'h900) begin
      m_dir = d[31];
      m_idx = d[IFW-1:0];
    end else if (sel_valid()) begin
      case (ofs)
        12'h904: m_kind[i] = d[2:0];
        12'h908: m_en[i]   = d[31];
        12'h90C: m_blo[i]  = d;
        12'h910: m_bhi[i]  = d;
        12'h914: m_lim[i]  = d;
        12'h918: m_tlo[i]  = d;
        12'h91C: m_thi[i]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = ofs;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
    model_write(ofs, d);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] ofs);
    @(negedge clk);
    reg_addr = ofs;
    #1;
    chk(tag, $sformatf("read %h", ofs), {32'h0, reg_rdata}, {32'h0, model_read(ofs)});
  endtask

  task automatic xl_chk(input string tag, input logic [63:0] a);
    logic        e_hit;
    logic [63:0] e_addr;
    logic [2:0]  e_kind;
    int          e_reg;
    e_hit  = 1'b0;
    e_addr = a;
    e_kind = 3'd0;
    e_reg  = 0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (m_en[i] && a[63:32] == m_bhi[i] && a[31:0] >= m_blo[i] && a[31:0] <= m_lim[i]) begin
        e_hit  = 1'b1;
        e_addr = {m_thi[i], m_tlo[i]} + (a - {m_bhi[i], m_blo[i]});
        e_kind = m_kind[i];
        e_reg  = i;
      end
    end
    @(negedge clk);
    req_addr = a;
    #1;
    chk(tag, $sformatf("hit @%h", a), {63'h0, hit}, {63'h0, e_hit});
    chk(tag, $sformatf("addr @%h", a), xlat_addr, e_addr);
    chk(tag, $sformatf("kind @%h", a), {61'h0, xlat_type}, {61'h0, e_kind});
    if (e_hit) chk(tag, $sformatf("region @%h", a), 64'(hit_region), 64'(e_reg));
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 8; k++) rd_chk(tag, 12'h900 + 12'(4 * k));
  endtask

  bit finished = 1'b0;

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) begin
      m_en[i] = 0; m_kind[i] = 0; m_blo[i] = 0; m_bhi[i] = 0;
      m_lim[i] = 0; m_tlo[i] = 0; m_thi[i] = 0;
    end
    m_dir = 0;
    m_idx = 0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R4: reset state
    read_all("R4");
    xl_chk("R4", 64'h0);
    xl_chk("R4", 64'h1_2000_0000);

    // R1: select register keeps direction and index only
    wr(12'h900, 32'hFFFF_FFF2);
    rd_chk("R1", 12'h900);
    chk("R1", "select value", {32'h0, reg_rdata}, 64'h8000_0002);

    // R2: region 0 as type-0 configuration, bus 3 dev 5 fn 2
    wr(12'h900, 32'h0);
    wr(12'h904, 32'hFFFF_FFF4);
    wr(12'h90C, 32'h2000_0000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h2000_FFFF);
    wr(12'h918, 32'h032A_0000);
    wr(12'h91C, 32'h0);
    wr(12'h908, 32'hFFFF_FFFF);
    read_all("R2");
    chk("R2", "kind bits", {32'h0, model_read(12'h904)}, 64'h4);

    // R6: offset added to target, BDF fields preserved
    xl_chk("R6", 64'h1_2000_0104);
    chk("R6", "bus", 64'(xlat_addr[31:24]), 64'd3);
    chk("R6", "dev", 64'(xlat_addr[23:19]), 64'd5);
    chk("R6", "fn",  64'(xlat_addr[18:16]), 64'd2);

    // R5: both ends inclusive, neighbours outside
    xl_chk("R5", 64'h1_2000_0000);
    xl_chk("R5", 64'h1_1FFF_FFFF);
    xl_chk("R5", 64'h1_2000_FFFF);
    xl_chk("R5", 64'h1_2001_0000);
    xl_chk("R5", 64'h0_2000_0100);

    // R8: overlapping memory region 1, lower index wins
    wr(12'h900, 32'h1);
    wr(12'h904, 32'h0);
    wr(12'h90C, 32'h2000_8000);
    wr(12'h910, 32'h1);
    wr(12'h914, 32'h2001_FFFF);
    wr(12'h918, 32'hC000_0000);
    wr(12'h91C, 32'h0000_00AB);
    wr(12'h908, 32'h8000_0000);
    xl_chk("R8", 64'h1_2000_9000);
    chk("R8", "winner", 64'(hit_region), 64'd0);
    xl_chk("R6", 64'h1_2001_0010);
    chk("R6", "mem target", xlat_addr, 64'hAB_C000_8010);

    // R7: disabled region 0 no longer hits
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h0);
    xl_chk("R7", 64'h1_2000_9000);
    chk("R7", "winner", 64'(hit_region), 64'd1);

    // R3: inbound and out-of-range selections
    wr(12'h900, 32'h8000_0000);
    wr(12'h90C, 32'hDEAD_0000);
    wr(12'h908, 32'h8000_0000);
    read_all("R3");
    wr(12'h900, 32'h7);
    wr(12'h908, 32'h8000_0000);
    wr(12'h914, 32'hFFFF_FFFF);
    read_all("R3");
    wr(12'h900, 32'h0);
    rd_chk("R3", 12'h90C);
    rd_chk("R3", 12'h908);
    rd_chk("R3", 12'h920);
    rd_chk("R3", 12'h906);
    wr(12'h906, 32'hFFFF_FFFF);
    rd_chk("R3", 12'h904);

    // R9: miss passes through
    xl_chk("R9", 64'h1_2000_0104);
    xl_chk("R9", 64'hFFFF_0000_1234_5678);

    // R10: reprogramming takes effect immediately after the write
    wr(12'h908, 32'h8000_0000);
    xl_chk("R10", 64'h1_2000_0200);
    wr(12'h904, 32'h5);
    xl_chk("R10", 64'h1_2000_0200);
    chk("R10", "kind cfg1", 64'(xlat_type), 64'd5);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 4) begin
        logic [11:0] ofs;
        logic [31:0] d;
        int f;
        f = int'($urandom_range(0, 7));
        ofs = 12'h900 + 12'(4 * f);
        case (f)
          0: d = {($urandom_range(0, 5) == 0), 27'h0, 4'($urandom_range(0, 5))};
          1: d = $urandom();
          2: d = {$urandom_range(0, 3) != 0, 31'($urandom())};
          3, 5: d = {4'h0, 4'($urandom_range(0, 15)), 24'($urandom_range(0, 255)) << 12};
          4: d = 32'($urandom_range(0, 1));
          default: d = $urandom();
        endcase
        wr(ofs, d);
        if ($urandom_range(0, 1) == 1) rd_chk("R2", ofs);
      end else if (sel < 8) begin
        int r;
        logic [63:0] a;
        r = int'($urandom_range(0, NR - 1));
        case ($urandom_range(0, 4))
          0: a = {m_bhi[r], m_blo[r]};
          1: a = {m_bhi[r], m_blo[r] - 32'd1};
          2: a = {m_bhi[r], m_lim[r]};
          3: a = {m_bhi[r], m_lim[r] + 32'd1};
          default: a = {32'($urandom_range(0, 1)), 4'h0, 4'($urandom_range(0, 15)), 24'($urandom())};
        endcase
        xl_chk("R5", a);
      end else begin
        rd_chk("R3", 12'h900 + 12'(4 * $urandom_range(0, 8)));
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule